// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block provides three independent 16-bit down-counters that share one slow count enable (nominally a 2 MHz strobe derived from the system clock). Software programs it through four byte-wide ports on an 8-bit I/O bus. Three of the ports carry count values, one for each channel. The fourth port takes a control word. The control word picks a channel and sets how that channel accepts its count bytes, which counting mode it uses, and whether it should count in decimal.

When a channel reaches terminal count it emits a one-cycle interrupt pulse on its own output line. These lines are meant to drive inputs 1, 2 and 3 of the downstream (slave) interrupt controller. Two modes are supported. A one-shot channel fires once and then goes idle. A periodic channel reloads its programmed value and fires again every period. The decimal-count request is recorded but not honoured: counting stays binary, and an error output reports that such a request is in force.

Top module: `pit3_timer`

## Requirements
- R1: After reset, `irq` is all zero, `bcd_err` is 0, and a read of the control port (addr 3) returns 0x00.
- R2: A read with `rd_en` high at addr 3 shows, on `rdata` in the following cycle, the last byte written to addr 3. The selector value does not matter.
- R3: Control word layout: bits 7:6 select the channel, bits 5:4 give the load format, bits 3:1 give the mode and bit 0 is the decimal flag. With load format 3, the first data write to a channel's port (addr 0, 1 or 2) is the low byte and the second is the high byte. Counting starts only after the second byte. The interrupt fires on the N-th enabled tick after the load.
- R4: With load format 2, one data write loads the high byte, with the low byte taken as zero. Counting starts at once, so value H fires after H*256 ticks.
- R5: In mode 0 the channel pulses once at terminal count and then stays silent until it is loaded again.
- R6: In mode 3 the channel pulses every N ticks, reloading its programmed value each time.
- R7: A loaded value of 0 counts as 65536 ticks.
- R8: A control-port write discards any pending low byte and returns the shared byte pointer to the first byte.
- R9: A control-port write that selects a running channel stops it.
- R10: `bcd_err` is high while any channel holds a control word with bit 0 set. Such a channel still counts in binary.
- R11: Channel c drives only `irq[c]`. Channels that reach terminal count on the same tick pulse together.
- R12: Each interrupt pulse lasts exactly one clock cycle and appears only in the cycle after an enabled tick.
- R13: A control-port write that selects a channel in the same cycle as that channel's terminal-count tick takes priority: no pulse is produced and the channel stops.
- R14: Once a channel's load is complete, further data writes are ignored until the next control-port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable; one pulse decrements every running channel |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Port select: 0..2 channel data, 3 control |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Registered read data (control readback, else 0) |
| irq | output | 3 | Per-channel terminal-count pulses |
| bcd_err | output | 1 | A channel holds an unsupported decimal request |

## Verification
A control-port write can land in the same cycle as a tick that would take the selected channel to terminal count. The bench provokes this by loading a count of 2, giving one tick, and then asserting `tick_en` and a control write together. It expects `irq` to stay low in that cycle and over the ticks that follow. The same bench also has two channels reach terminal count on a shared tick, and it requires both bits of `irq` in the one cycle.

// File: rtl/pit3_pkg.sv
package pit3_pkg;
  localparam int DATA_W = 8;

  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam logic [1:0] FMT_HIGH  = 2'd2;
  localparam logic [1:0] FMT_BOTH  = 2'd3;
  localparam logic [2:0] MODE_ONESHOT  = 3'd0;
  localparam logic [2:0] MODE_PERIODIC = 3'd3;

  typedef enum logic [1:0] {
    PTR_FIRST  = 2'd0,
    PTR_SECOND = 2'd1,
    PTR_DONE   = 2'd2
  } byte_ptr_e;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] fmt;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_word_t;
endpackage

// File: rtl/pit3_loader.sv
module pit3_loader import pit3_pkg::*; #(
  parameter int NUM_CH = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     ctrl_q,
  output logic                  bcd_any,
  output logic [NUM_CH-1:0]     cfg_stb,
  output logic [2:0]            cfg_mode,
  output logic [NUM_CH-1:0]     ld_stb,
  output logic [2*DATA_W-1:0]   ld_val
);
  localparam logic [1:0] LAST_CH = 2'(NUM_CH - 1);

  ctrl_word_t         cw;
  byte_ptr_e          ptr_q;
  logic [DATA_W-1:0]  pend_q;
  logic [1:0]         fmt_q [NUM_CH];
  logic [NUM_CH-1:0]  bcd_q;
  logic               ctrl_hit;
  logic               data_hit;
  logic [1:0]         cur_fmt;

  assign cw       = ctrl_word_t'(wdata);
  assign ctrl_hit = wr_en && (addr == CTRL_ADDR);
  assign data_hit = wr_en && (addr != CTRL_ADDR) && (addr <= LAST_CH);
  assign cfg_mode = cw.mode;
  assign bcd_any  = |bcd_q;
  assign ld_val   = {wdata, (ptr_q == PTR_SECOND) ? pend_q : {DATA_W{1'b0}}};

  always_comb begin
    cur_fmt = 2'd0;
    for (int c = 0; c < NUM_CH; c++) begin
      cfg_stb[c] = ctrl_hit && (cw.sel == 2'(c));
      ld_stb[c]  = data_hit && (addr == 2'(c)) &&
                   (((fmt_q[c] == FMT_BOTH) && (ptr_q == PTR_SECOND)) ||
                    ((fmt_q[c] == FMT_HIGH) && (ptr_q == PTR_FIRST)));
      if (addr == 2'(c)) cur_fmt = fmt_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ptr_q  <= PTR_FIRST;
      pend_q <= '0;
      bcd_q  <= '0;
      for (int c = 0; c < NUM_CH; c++) fmt_q[c] <= 2'd0;
    end else if (ctrl_hit) begin
      ctrl_q <= wdata;
      ptr_q  <= PTR_FIRST;
      pend_q <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (cw.sel == 2'(c)) begin
          fmt_q[c] <= cw.fmt;
          bcd_q[c] <= cw.bcd;
        end
      end
    end else if (data_hit) begin
      if (cur_fmt == FMT_BOTH) begin
        if (ptr_q == PTR_FIRST) begin
          pend_q <= wdata;
          ptr_q  <= PTR_SECOND;
        end else if (ptr_q == PTR_SECOND) begin
          ptr_q  <= PTR_DONE;
        end
      end else if (cur_fmt == FMT_HIGH) begin
        if (ptr_q == PTR_FIRST) ptr_q <= PTR_DONE;
      end
    end
  end

  // R3: a load only ever comes from a data-port write
  assert_load_from_data_R3: assert property (@(posedge clk) disable iff (rst)
    (|ld_stb) |-> (wr_en && (addr != CTRL_ADDR)));

  // R14: after completion, no load until a control write re-arms the pointer
  assert_done_blocks_load_R14: assert property (@(posedge clk) disable iff (rst)
    (ptr_q == PTR_DONE) |-> (ld_stb == '0));
endmodule

// File: rtl/pit3_channel.sv
module pit3_channel import pit3_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cfg_stb,
  input  logic [2:0]       cfg_mode,
  input  logic             ld_stb,
  input  logic [CNT_W-1:0] ld_val,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;
  logic [2:0]       mode_q;
  logic             running_q;
  logic             terminal;

  assign terminal = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      reload_q  <= '0;
      mode_q    <= MODE_ONESHOT;
      running_q <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (cfg_stb) begin
        mode_q    <= cfg_mode;
        running_q <= 1'b0;
      end else if (ld_stb) begin
        cnt_q     <= ld_val;
        reload_q  <= ld_val;
        running_q <= (mode_q == MODE_ONESHOT) || (mode_q == MODE_PERIODIC);
      end else if (tick && running_q) begin
        if (terminal) begin
          irq <= 1'b1;
          if (mode_q == MODE_PERIODIC) cnt_q <= reload_q;
          else                         running_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  // R12: a pulse only follows an enabled tick of a running channel
  assert_irq_after_tick_R12: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tick && running_q));

  // R5: one-shot channel is idle when it pulses
  assert_oneshot_stops_R5: assert property (@(posedge clk) disable iff (rst)
    (irq && (mode_q == MODE_ONESHOT)) |-> !running_q);

  // R6: periodic channel keeps running across its pulse
  assert_periodic_runs_R6: assert property (@(posedge clk) disable iff (rst)
    (irq && (mode_q == MODE_PERIODIC)) |-> running_q);

  // R13: a control write for this channel never coincides with a next-cycle pulse
  assert_cfg_wins_R13: assert property (@(posedge clk) disable iff (rst)
    cfg_stb |=> !irq);
endmodule

// File: rtl/pit3_timer.sv
module pit3_timer import pit3_pkg::*; #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [NUM_CH-1:0] irq,
  output logic              bcd_err
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [1:0] LAST_CH = 2'(NUM_CH - 1);

  logic [DATA_W-1:0] ctrl_q;
  logic [NUM_CH-1:0] cfg_stb;
  logic [2:0]        cfg_mode;
  logic [NUM_CH-1:0] ld_stb;
  logic [CNT_W-1:0]  ld_val;

  pit3_loader #(.NUM_CH(NUM_CH)) u_loader (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .ctrl_q   (ctrl_q),
    .bcd_any  (bcd_err),
    .cfg_stb  (cfg_stb),
    .cfg_mode (cfg_mode),
    .ld_stb   (ld_stb),
    .ld_val   (ld_val)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pit3_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick_en),
      .cfg_stb  (cfg_stb[c]),
      .cfg_mode (cfg_mode),
      .ld_stb   (ld_stb[c]),
      .ld_val   (ld_val),
      .irq      (irq[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= (rd_en && (addr == CTRL_ADDR)) ? ctrl_q : '0;
  end

  // R10: programming a channel with the decimal flag raises the error output
  assert_bcd_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == CTRL_ADDR) && wdata[0] && (wdata[7:6] <= LAST_CH)) |=> bcd_err);

  // R2: control readback carries the byte of a control write that just happened
  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == CTRL_ADDR)) ##1 (rd_en && (addr == CTRL_ADDR)) |=> (rdata == $past(wdata, 2)));
endmodule

// File: tb/pit3_timer_bench.sv
module pit3_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [2:0] irq;
  logic       bcd_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pit3_timer u_pit3_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .bcd_err(bcd_err)
  );

  // {ch[39:38], fmt[37:36], mode[35:33], lo[32:25], hi[24:17], ticks[16:0]}
  localparam logic [39:0] VEC [6] = '{
    {2'd0, 2'd3, 3'd0, 8'h05, 8'h00, 17'd5},
    {2'd1, 2'd3, 3'd3, 8'h03, 8'h00, 17'd3},
    {2'd2, 2'd2, 3'd0, 8'h00, 8'h01, 17'd256},
    {2'd0, 2'd3, 3'd0, 8'h00, 8'h01, 17'd256},
    {2'd1, 2'd3, 3'd0, 8'h01, 8'h00, 17'd1},
    {2'd2, 2'd2, 3'd3, 8'h00, 8'h02, 17'd512}
  };

  function automatic logic [7:0] cw(input logic [1:0] ch, input logic [1:0] fmt,
                                    input logic [2:0] mode, input logic bcd);
    return {ch, fmt, mode, bcd};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick1();
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic rd_ctrl(output logic [7:0] v);
    rd_en = 1'b1; addr = 2'd3;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  // ticks until irq[ch]; returns 0 if none; flags stray channels (R11)
  task automatic to_pulse(input int ch, input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      tick1();
      if (irq != 3'b000) begin
        if (irq != (3'b001 << ch)) check("R11", 32'(irq), 32'(3'b001 << ch));
        n = i + 1;
        break;
      end
    end
  endtask

  task automatic quiet(input int ticks, output int seen);
    seen = 0;
    for (int i = 0; i < ticks; i++) begin
      tick1();
      if (irq != 3'b000) seen++;
    end
  endtask

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1", 32'(irq), 0);
    check("R1", 32'(bcd_err), 0);
    rd_ctrl(v);
    check("R1", 32'(v), 0);

    // R2 readback, selector 3 included
    wr(2'd3, 8'hF6);
    rd_ctrl(v);
    check("R2", 32'(v), 32'h F6);

    // vector table: R3 / R4 / R6 first period
    for (int i = 0; i < 6; i++) begin
      logic [39:0] e;
      e = VEC[i];
      wr(2'd3, cw(e[39:38], e[37:36], e[35:33], 1'b0));
      if (e[37:36] == 2'd3) begin
        wr(e[39:38], e[32:25]);
        wr(e[39:38], e[24:17]);
      end else begin
        wr(e[39:38], e[24:17]);
      end
      to_pulse(int'(e[39:38]), int'(e[16:0]) + 8, n);
      check(e[37:36] == 2'd3 ? "R3" : "R4", 32'(n), 32'(e[16:0]));
      @(negedge clk);
      check("R12", 32'(irq), 0);
      wr(2'd3, cw(e[39:38], 2'd3, 3'd0, 1'b0));
    end

    // R3 no counting after only the first byte
    wr(2'd3, cw(2'd0, 2'd3, 3'd0, 1'b0));
    wr(2'd0, 8'h02);
    quiet(6, n);
    check("R3", 32'(n), 0);

    // R5 one-shot stays silent
    wr(2'd3, cw(2'd0, 2'd3, 3'd0, 1'b0));
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    to_pulse(0, 10, n);
    check("R5", 32'(n), 3);
    quiet(12, n);
    check("R5", 32'(n), 0);

    // R6 periodic
    wr(2'd3, cw(2'd1, 2'd3, 3'd3, 1'b0));
    wr(2'd1, 8'h04); wr(2'd1, 8'h00);
    for (int k = 0; k < 3; k++) begin
      to_pulse(1, 10, n);
      check("R6", 32'(n), 4);
    end
    // R9 control write stops running channel
    wr(2'd3, cw(2'd1, 2'd3, 3'd0, 1'b0));
    quiet(10, n);
    check("R9", 32'(n), 0);

    // R8 pending low byte discarded
    wr(2'd3, cw(2'd0, 2'd3, 3'd0, 1'b0));
    wr(2'd0, 8'h99);
    wr(2'd3, cw(2'd0, 2'd3, 3'd0, 1'b0));
    wr(2'd0, 8'h02); wr(2'd0, 8'h00);
    to_pulse(0, 300, n);
    check("R8", 32'(n), 2);

    // R10 decimal flag: error raised, counting binary
    wr(2'd3, cw(2'd2, 2'd3, 3'd0, 1'b1));
    check("R10", 32'(bcd_err), 1);
    wr(2'd2, 8'h10); wr(2'd2, 8'h00);
    to_pulse(2, 30, n);
    check("R10", 32'(n), 16);
    wr(2'd3, cw(2'd2, 2'd3, 3'd0, 1'b0));
    check("R10", 32'(bcd_err), 0);

    // R11 two channels on the same tick
    wr(2'd3, cw(2'd0, 2'd3, 3'd0, 1'b0));
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    wr(2'd3, cw(2'd1, 2'd3, 3'd0, 1'b0));
    wr(2'd1, 8'h03); wr(2'd1, 8'h00);
    tick1(); tick1(); tick1();
    check("R11", 32'(irq), 32'(3'b011));

    // R13 control write collides with terminal tick
    wr(2'd3, cw(2'd2, 2'd3, 3'd0, 1'b0));
    wr(2'd2, 8'h02); wr(2'd2, 8'h00);
    tick1();
    tick_en = 1'b1; wr_en = 1'b1; addr = 2'd3; wdata = cw(2'd2, 2'd3, 3'd0, 1'b0);
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    check("R13", 32'(irq), 0);
    quiet(6, n);
    check("R13", 32'(n), 0);

    // R14 extra writes after completion ignored
    wr(2'd3, cw(2'd1, 2'd3, 3'd0, 1'b0));
    wr(2'd1, 8'h03); wr(2'd1, 8'h00); wr(2'd1, 8'h50);
    to_pulse(1, 100, n);
    check("R14", 32'(n), 3);
    wr(2'd3, cw(2'd0, 2'd2, 3'd0, 1'b0));
    wr(2'd0, 8'h01); wr(2'd0, 8'h05);
    to_pulse(0, 1400, n);
    check("R14", 32'(n), 256);

    // R7 zero means 65536
    wr(2'd3, cw(2'd2, 2'd3, 3'd0, 1'b0));
    wr(2'd2, 8'h00); wr(2'd2, 8'h00);
    to_pulse(2, 70000, n);
    check("R7", 32'(n), 65536);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule